// File: doc/BRIEF.md
# Triangular PWM Carrier Timer

This block generates a triangular PWM carrier with an up/down counter. The counter climbs from zero to an active peak value, turns, descends back to zero, and repeats. Each turning point (peak or bottom) is present for exactly one clock. Software loads a peak value and a compare-M value into buffer registers. A two-bit operating mode chooses the turning points at which the buffers are copied into the active registers. The mode also chooses where an A/D-start pulse is issued: always at the turning point opposite the copy point, or at both turning points in the mode that copies at both.

Two compare channels watch the counter. Channel M matches against the active compare-M value. Channel N matches against a directly written doubled-dead-time value. Each match sets a sticky flag and emits a one-cycle transfer-controller trigger. A set flag whose enable bit is 1 raises an interrupt request. Software clears a flag by writing 0 to its status bit.

Top module: `pwm_carrier_timer`

## Requirements
- R1: After reset the count is 0 and counting up. While the run bit (control bit 0) is 1, the count rises by one per clock up to the active peak. In the cycle it equals the peak, it reverses and steps down, reaching 0 for one cycle before rising to 1 again. An active peak of 0 holds the count at 0. While run is 0 the count holds.
- R2: While run is 0, each clock copies the peak buffer (address 2) and the compare-M buffer (address 3) into the active peak (address 5) and the active compare-M (address 6).
- R3: While running, the active registers load from the buffers only at turning points. Mode field control[5:4]: mode 1 loads at the peak, mode 2 at the bottom, mode 3 at both, mode 0 never.
- R4: `adc_start` is a one-cycle pulse in the cycle after a turning point. Mode 1 pulses after the bottom, mode 2 after the peak, mode 3 after both, and mode 0 never.
- R5: `adc_start` stays 0 whenever the trigger-enable bit (control bit 1) was 0 in the turning-point cycle.
- R6: While running, the cycle after the count equals the active compare-M value sets flag M (status bit 0) and pulses `xfer_m` for one cycle. The cycle after the count equals the dead-time value (address 4) sets flag N (status bit 1) and pulses `xfer_n`.
- R7: Writing status (address 1) with a bit at 0 clears that flag, and a 1 leaves it unchanged. If a set and a clear fall in the same cycle, the set wins.
- R8: `irq_m` is flag M AND enable bit control[2`; `irq_n` is flag N AND enable bit control[3].
- R9: `reg_rdata` returns the addressed register from current state: 0 control, 1 status, 2 peak buffer, 3 compare-M buffer, 4 dead-time value, 5 active peak, 6 active compare-M, 7 count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for `reg_addr` |
| count | output | CNT_W | Carrier counter value |
| count_up | output | 1 | 1 while counting up |
| adc_start | output | 1 | A/D start pulse |
| irq_m | output | 1 | Interrupt request, channel M |
| irq_n | output | 1 | Interrupt request, channel N |
| xfer_m | output | 1 | Transfer trigger, channel M |
| xfer_n | output | 1 | Transfer trigger, channel N |

## Verification
A hardware flag set and a software write of 0 to the same flag can fall in the same cycle. The bench provokes this by watching the count and issuing the clearing write in exactly the cycle the count equals the compare-M value. The flag must read 1 afterward. A buffer write can also coincide with a turning-point copy; in that case the copy must carry the buffer's previous value. A cycle-accurate reference model in the bench judges both cases while random register traffic runs against short carrier periods.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
   localparam int ADDR_W   = 3;
   localparam int A_CTRL   = 0;
   localparam int A_STAT   = 1;
   localparam int A_PEAKB  = 2;
   localparam int A_CMPB   = 3;
   localparam int A_DT2    = 4;
   localparam int A_PEAKA  = 5;
   localparam int A_CMPA   = 6;
   localparam int A_COUNT  = 7;
   localparam int B_RUN    = 0;
   localparam int B_TRG    = 1;
   localparam int B_IEM    = 2;
   localparam int B_IEN    = 3;
   localparam int B_MODE   = 4;
   localparam int NCH      = 2;
   typedef enum logic [1:0] {
      MODE_OFF    = 2'd0,
      MODE_PEAK   = 2'd1,
      MODE_BOTTOM = 2'd2,
      MODE_BOTH   = 2'd3
   } ptc_mode_e;
endpackage

// File: rtl/ptc_counter.sv
module ptc_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] peak,
   output logic [CNT_W-1:0] cnt,
   output logic             up,
   output logic             at_peak,
   output logic             at_bottom
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   assign at_peak   = run & up & (cnt >= peak);
   assign at_bottom = run & ~up & (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         up  <= 1'b1;
      end else if (run) begin
         if (at_peak) begin
            up  <= 1'b0;
            cnt <= (cnt == '0) ? '0 : cnt - ONE;
         end else if (at_bottom) begin
            up  <= 1'b1;
            cnt <= (peak == '0) ? '0 : ONE;
         end else if (up) begin
            cnt <= cnt + ONE;
         end else begin
            cnt <= cnt - ONE;
         end
      end
   end
endmodule

// File: rtl/ptc_events.sv
module ptc_events
   import ptc_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [1:0]       mode,
   input  logic             trg_en,
   input  logic             at_peak,
   input  logic             at_bottom,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp_m,
   input  logic [CNT_W-1:0] cmp_n,
   output logic             load_pt,
   output logic [NCH-1:0]   match,
   output logic [NCH-1:0]   pulse,
   output logic             adc_start
);
   logic [CNT_W-1:0] cmpv [NCH];
   logic             adc_ev;

   assign cmpv[0] = cmp_m;
   assign cmpv[1] = cmp_n;

   // bit 0 of mode: load at peak, trigger at bottom; bit 1: the reverse
   assign load_pt = (mode[0] & at_peak) | (mode[1] & at_bottom);
   assign adc_ev  = (mode[0] & at_bottom) | (mode[1] & at_peak);

   for (genvar k = 0; k < NCH; k++) begin : g_ch
      assign match[k] = run & (cnt == cmpv[k]);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pulse[k] <= 1'b0;
         else        pulse[k] <= match[k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) adc_start <= 1'b0;
      else        adc_start <= trg_en & adc_ev;
   end
endmodule

// File: rtl/ptc_regs.sv
module ptc_regs
   import ptc_pkg::*;
#(
   parameter int               CNT_W    = 16,
   parameter logic [CNT_W-1:0] PEAK_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  wdata,
   input  logic              load_pt,
   input  logic [NCH-1:0]    match,
   input  logic [CNT_W-1:0]  cnt,
   output logic              run,
   output logic              trg_en,
   output logic              ie_m,
   output logic              ie_n,
   output logic [1:0]        mode,
   output logic [NCH-1:0]    flags,
   output logic [CNT_W-1:0]  peak_act,
   output logic [CNT_W-1:0]  cmp_act,
   output logic [CNT_W-1:0]  dt2,
   output logic [CNT_W-1:0]  rdata
);
   logic [CNT_W-1:0] peak_buf, cmp_buf;
   logic             load_act;

   assign load_act = ~run | load_pt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0; trg_en <= 1'b0; ie_m <= 1'b0; ie_n <= 1'b0;
         mode     <= MODE_OFF;
         peak_buf <= PEAK_RST;
         cmp_buf  <= '0;
         dt2      <= '0;
      end else if (we) begin
         case (int'(addr))
            A_CTRL: begin
               run    <= wdata[B_RUN];
               trg_en <= wdata[B_TRG];
               ie_m   <= wdata[B_IEM];
               ie_n   <= wdata[B_IEN];
               mode   <= wdata[B_MODE+:2];
            end
            A_PEAKB: peak_buf <= wdata;
            A_CMPB:  cmp_buf  <= wdata;
            A_DT2:   dt2      <= wdata;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         peak_act <= PEAK_RST;
         cmp_act  <= '0;
      end else if (load_act) begin
         peak_act <= peak_buf;
         cmp_act  <= cmp_buf;
      end
   end

   for (genvar k = 0; k < NCH; k++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flags[k] <= 1'b0;
         else if (match[k])
            flags[k] <= 1'b1;
         else if (we && int'(addr) == A_STAT && !wdata[k])
            flags[k] <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      case (int'(addr))
         A_CTRL:  rdata[B_MODE+1:0] = {mode, ie_n, ie_m, trg_en, run};
         A_STAT:  rdata[NCH-1:0]    = flags;
         A_PEAKB: rdata = peak_buf;
         A_CMPB:  rdata = cmp_buf;
         A_DT2:   rdata = dt2;
         A_PEAKA: rdata = peak_act;
         A_CMPA:  rdata = cmp_act;
         default: rdata = cnt;
      endcase
   end
endmodule

// File: rtl/pwm_carrier_timer.sv
module pwm_carrier_timer
   import ptc_pkg::*;
#(
   parameter int               CNT_W    = 16,
   parameter logic [CNT_W-1:0] PEAK_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [CNT_W-1:0]  reg_wdata,
   output logic [CNT_W-1:0]  reg_rdata,
   output logic [CNT_W-1:0]  count,
   output logic              count_up,
   output logic              adc_start,
   output logic              irq_m,
   output logic              irq_n,
   output logic              xfer_m,
   output logic              xfer_n
);
   if (CNT_W < 8) begin : g_w_chk
      $error("CNT_W must be at least 8 to hold the control fields");
   end
   if (ADDR_W != 3) begin : g_a_chk
      $error("register map needs a 3-bit address");
   end

   logic             run, trg_en, ie_m, ie_n, at_peak, at_bottom, load_pt;
   logic [1:0]       mode;
   logic [NCH-1:0]   flags, match, pulse;
   logic [CNT_W-1:0] peak_act, cmp_act, dt2;

   ptc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run), .peak(peak_act),
      .cnt(count), .up(count_up), .at_peak(at_peak), .at_bottom(at_bottom)
   );

   ptc_events #(.CNT_W(CNT_W)) u_evt (
      .clk(clk), .rst_n(rst_n), .run(run), .mode(mode), .trg_en(trg_en),
      .at_peak(at_peak), .at_bottom(at_bottom), .cnt(count),
      .cmp_m(cmp_act), .cmp_n(dt2), .load_pt(load_pt), .match(match),
      .pulse(pulse), .adc_start(adc_start)
   );

   ptc_regs #(.CNT_W(CNT_W), .PEAK_RST(PEAK_RST)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .load_pt(load_pt), .match(match), .cnt(count),
      .run(run), .trg_en(trg_en), .ie_m(ie_m), .ie_n(ie_n), .mode(mode),
      .flags(flags), .peak_act(peak_act), .cmp_act(cmp_act), .dt2(dt2),
      .rdata(reg_rdata)
   );

   assign irq_m  = flags[0] & ie_m;
   assign irq_n  = flags[1] & ie_n;
   assign xfer_m = pulse[0];
   assign xfer_n = pulse[1];
endmodule

// File: rtl/ptc_checker.sv
module ptc_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             trg_en,
   input logic [1:0]       mode,
   input logic [CNT_W-1:0] peak_act,
   input logic [CNT_W-1:0] count,
   input logic             adc_start,
   input logic [1:0]       flags,
   input logic             xfer_m
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   a_r1_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> (count == $past(count) || count == $past(count) + ONE
               || count == $past(count) - ONE));

   a_r3_mode0_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (run && mode == 2'b00) |=> $stable(peak_act));

   a_r5_adc_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start |-> $past(trg_en));

   a_r6_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_m |-> flags[0]);

   a_r7_rise_from_match: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[0]) |-> xfer_m);
endmodule

bind pwm_carrier_timer ptc_checker #(.CNT_W(CNT_W)) u_ptc_chk (
   .clk(clk), .rst_n(rst_n), .run(run), .trg_en(trg_en), .mode(mode),
   .peak_act(peak_act), .count(count), .adc_start(adc_start),
   .flags(flags), .xfer_m(xfer_m)
);

// File: tb/pwm_carrier_timer_bench.sv
module pwm_carrier_timer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int W = 16;
   localparam logic [W-1:0] PRST = 16'd12;

   logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
   logic [2:0] addr = '0;
   logic [W-1:0] wdata = '0;
   logic [W-1:0] rdata, count;
   logic cup, adc, irqm, irqn, xm, xn;
   int nchk = 0, nerr = 0;

   // reference model state
   int m_cnt, m_up, m_pact, m_cact, m_pbuf, m_cbuf, m_dt, m_ctrl, m_fm, m_fn;
   int m_adc, m_xm, m_xn;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwm_carrier_timer #(.CNT_W(W), .PEAK_RST(PRST)) u_pwm_carrier_timer (
      .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr),
      .reg_wdata(wdata), .reg_rdata(rdata), .count(count), .count_up(cup),
      .adc_start(adc), .irq_m(irqm), .irq_n(irqn), .xfer_m(xm), .xfer_n(xn)
   );

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int rd_model(input int a);
      case (a)
         0: return m_ctrl;
         1: return (m_fn << 1) | m_fm;
         2: return m_pbuf;
         3: return m_cbuf;
         4: return m_dt;
         5: return m_pact;
         6: return m_cact;
         default: return m_cnt;
      endcase
   endfunction

   task automatic model_reset();
      m_cnt = 0; m_up = 1; m_pact = PRST; m_pbuf = PRST; m_cact = 0; m_cbuf = 0;
      m_dt = 0; m_ctrl = 0; m_fm = 0; m_fn = 0; m_adc = 0; m_xm = 0; m_xn = 0;
   endtask

   task automatic model_step(input int w, input int a, input int d);
      int run, md, atp, atb, ld, ae, hm, hn, ncnt, nup;
      run = m_ctrl & 1;
      md  = (m_ctrl >> 4) & 3;
      atp = run && m_up && (m_cnt >= m_pact);
      atb = run && !m_up && (m_cnt == 0);
      ld  = ((md & 1) && atp) || ((md & 2) && atb);
      ae  = ((md & 1) && atb) || ((md & 2) && atp);
      hm  = run && (m_cnt == m_cact);
      hn  = run && (m_cnt == m_dt);
      ncnt = m_cnt; nup = m_up;
      if (run) begin
         if (atp) begin nup = 0; ncnt = (m_cnt == 0) ? 0 : m_cnt - 1; end
         else if (atb) begin nup = 1; ncnt = (m_pact == 0) ? 0 : 1; end
         else if (m_up) ncnt = m_cnt + 1;
         else ncnt = m_cnt - 1;
      end
      m_adc = ae && ((m_ctrl >> 1) & 1);
      m_xm = hm; m_xn = hn;
      if (hm) m_fm = 1; else if (w && a == 1 && !(d & 1)) m_fm = 0;
      if (hn) m_fn = 1; else if (w && a == 1 && !(d & 2)) m_fn = 0;
      if (!run || ld) begin m_pact = m_pbuf; m_cact = m_cbuf; end
      m_cnt = ncnt; m_up = nup;
      if (w) case (a)
         0: m_ctrl = d & 63;
         2: m_pbuf = d;
         3: m_cbuf = d;
         4: m_dt   = d;
         default: ;
      endcase
   endtask

   task automatic compare_all();
      chk("R1 count", int'(count), m_cnt);
      chk("R1 direction", int'(cup), m_up);
      chk("R4 R5 adc_start", int'(adc), m_adc);
      chk("R6 xfer_m", int'(xm), m_xm);
      chk("R6 xfer_n", int'(xn), m_xn);
      chk("R8 irq_m", int'(irqm), m_fm & ((m_ctrl >> 2) & 1));
      chk("R8 irq_n", int'(irqn), m_fn & ((m_ctrl >> 3) & 1));
      chk("R9 R2 R3 R7 readback", int'(rdata), rd_model(int'(addr)));
   endtask

   task automatic tick();
      int w, a, d;
      w = we; a = int'(addr); d = int'(wdata);
      @(posedge clk); #1;
      model_step(w, a, d);
      compare_all();
   endtask

   task automatic wr(input int a, input int d);
      we = 1'b1; addr = 3'(a); wdata = W'(d);
      tick();
      we = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      model_reset();
      repeat (3) @(posedge clk);
      #1;
      // reset state, R1 and R9
      chk("R1 reset count", int'(count), 0);
      chk("R1 reset direction", int'(cup), 1);
      addr = 3'd5; #1;
      chk("R9 reset active peak", int'(rdata), int'(PRST));
      rst_n = 1'b1;
      tick();

      // R2: stopped, active follows buffers
      wr(2, 6); wr(3, 4); tick();
      addr = 3'd5; #1;
      chk("R2 stopped copy of peak", int'(rdata), 6);

      // R7 collision: write 0 to flag M in the match cycle
      wr(0, 1);
      while (m_cnt != 3) tick();
      wr(1, 0);
      wr(1, 0);
      addr = 3'd1; #1;
      chk("R7 set wins over clear", int'(rdata) & 1, 1);
      wr(1, 2);
      chk("R7 write zero clears", int'(rdata) & 1, 0);

      // R4 directed: mode 2 with trigger, adc after the peak
      wr(0, 32'h23);
      for (int i = 0; i < 40; i++) tick();
      // R5: mode 3 without trigger enable
      wr(0, 32'h31);
      for (int i = 0; i < 40; i++) begin
         tick();
         chk("R5 no adc when disabled", int'(adc), 0);
      end

      // random phase
      for (int i = 0; i < 6000; i++) begin
         int r;
         r = int'($urandom_range(0, 15));
         addr = 3'($urandom_range(0, 7));
         if (r == 0) begin
            int d;
            d = int'($urandom_range(0, 63));
            if ($urandom_range(0, 7) != 0) d = d | 1;
            wr(0, d);
         end else if (r == 1) wr(1, int'($urandom_range(0, 3)));
         else if (r == 2) wr(2, int'($urandom_range(0, 12)));
         else if (r == 3) wr(3, int'($urandom_range(0, 12)));
         else if (r == 4) wr(4, int'($urandom_range(0, 12)));
         else tick();
      end

      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end
endmodule